// File: doc/BRIEF.md
# Load/Store Address and Lane Unit

This block sits between the decode stage and the data-memory port of a 32-bit core. For every load or store it works out the effective byte address, the access width, whether the result is sign-extended, the byte enables, and, for the auto-update forms, the new value of the base register together with a write-enable for it. All of these are registered, so they appear on the ports one clock after the request. In that same cycle the memory returns a 32-bit word. The block then picks the addressed byte or halfword out of that word and widens it into the value bound for the destination register.

Three addressing forms exist:

- **Displacement.** The access uses the base plus a signed 15-bit offset, and the base is left unchanged.
- **Pre-update.** The base plus a signed 12-bit offset serves as both the access address and the new base.
- **Post-update.** The access uses the unchanged base, and the base is then advanced by the signed 12-bit offset.

A cache-maintenance opcode produces an address and nothing else. The register file and the memory live outside the block.

Top module: `lsu_addr_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, mem_rd, mem_wr, mem_be, misalign, base_we, mem_sext and load_value are all zero.
- R2: Access kind is decoded from a 3-bit code, taken from req_func for opcodes 0x03/0x07 and from req_opcode[2:0] for opcodes 0x10..0x17. The codes are: 0 word load, 1 signed half load, 2 unsigned half load, 3 signed byte load, 4 word store, 5 half store, 6 unsigned byte load, 7 byte store. mem_size reports 0 byte, 1 half, 2 word. mem_sext is 1 only for codes 1 and 3, and mem_rd and mem_wr are never high together.
- R3: Opcode 0x03 (pre-update): mem_addr and base_next both equal req_base + sign-extended req_imm[11:0], and base_we = 1. req_imm[14:12] is ignored.
- R4: Opcode 0x07 (post-update): mem_addr = req_base, base_next = req_base + sign-extended req_imm[11:0], and base_we = 1.
- R5: Opcodes 0x10..0x17 (displacement): mem_addr = req_base + sign-extended req_imm[14:0], and base_we = 0.
- R6: Opcode 0x18 (cache operation): mem_addr = req_base + sign-extended req_imm[14:0]. mem_rd, mem_wr, mem_be, misalign and base_we all stay 0.
- R7: Byte enables follow little-endian lanes, with bit i covering bits 8i+7..8i of the bus word. A byte access sets bit addr[1:0]. A half access sets 4'b0011 or 4'b1100 as addr[1] is 0 or 1. A word access sets 4'b1111. Enables are driven for both loads and stores.
- R8: A word access with addr[1:0] != 0, or a half access with addr[0] = 1, sets misalign and clears mem_rd, mem_wr, mem_be, mem_sext and base_we.
- R9: While mem_rd is high, load_value is formed from rd_word as follows. Word loads pass rd_word through. Half loads take the half chosen by addr[1], and byte loads take the byte chosen by addr[1:0]. Signed loads then sign-extend from bit 15 or bit 7, and unsigned loads fill with zeros. load_value is 0 when mem_rd is low.
- R10: Outputs appear one clock after the request. A cycle with req_valid low, or with an opcode outside the ones above, yields mem_rd = mem_wr = base_we = misalign = 0 and mem_addr = 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_opcode | input | 5 | Major opcode |
| req_func | input | 3 | Size/direction code for the update forms |
| req_base | input | 32 | Base register value |
| req_imm | input | 15 | Immediate offset field |
| rd_word | input | 32 | Word returned by memory for the current output |
| mem_addr | output | 32 | Effective byte address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_size | output | 2 | 0 byte, 1 half, 2 word |
| mem_sext | output | 1 | Load result is sign-extended |
| mem_be | output | 4 | Byte enables |
| misalign | output | 1 | Access squashed for misalignment |
| base_next | output | 32 | Updated base value |
| base_we | output | 1 | Base register write-enable |
| load_value | output | 32 | Aligned and extended load result |

## Verification
Each request's state is held in a single register stage. A wrong decode, a wrong offset width or a mis-chosen address source therefore shows up on mem_addr, the strobes or base_next in the very next cycle, and a later request can never hide it. A wrong lane choice or a lost sign bit shows up at once on load_value, because that path has no register of its own. The sweeps cover every size code under every address remainder in all three addressing forms. This makes a misalignment rule that fires in the wrong case, or a byte enable in the wrong lane, visible within a single request.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int XLEN       = 32;
    localparam int NBYTES     = XLEN / 8;
    localparam int OPC_W      = 5;
    localparam int IMM_W      = 15;
    localparam int UPD_OFF_W  = 12;
    localparam int DISP_OFF_W = 15;

    localparam logic [OPC_W-1:0] OP_PRE   = 5'h03;
    localparam logic [OPC_W-1:0] OP_POST  = 5'h07;
    localparam logic [OPC_W-1:0] OP_DISP  = 5'h10;
    localparam logic [OPC_W-1:0] OP_CACHE = 5'h18;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [2:0] {
        AM_NONE,
        AM_DISP,
        AM_PRE,
        AM_POST,
        AM_CACHE
    } amode_e;

    typedef struct packed {
        logic  ld;
        logic  st;
        size_e size;
        logic  sext;
    } access_t;

    function automatic access_t kind_of(input logic [2:0] code);
        access_t a;
        a = '0;
        case (code)
            3'd0: begin a.ld = 1'b1; a.size = SZ_WORD; end
            3'd1: begin a.ld = 1'b1; a.size = SZ_HALF; a.sext = 1'b1; end
            3'd2: begin a.ld = 1'b1; a.size = SZ_HALF; end
            3'd3: begin a.ld = 1'b1; a.size = SZ_BYTE; a.sext = 1'b1; end
            3'd4: begin a.st = 1'b1; a.size = SZ_WORD; end
            3'd5: begin a.st = 1'b1; a.size = SZ_HALF; end
            3'd6: begin a.ld = 1'b1; a.size = SZ_BYTE; end
            default: begin a.st = 1'b1; a.size = SZ_BYTE; end
        endcase
        return a;
    endfunction

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [2:0]       func,
    output amode_e           amode,
    output access_t          acc
);
    localparam logic [OPC_W-4:0] DISP_HI = OP_DISP[OPC_W-1:3];

    always_comb begin
        amode = AM_NONE;
        acc   = '0;
        if (opcode == OP_PRE) begin
            amode = AM_PRE;
            acc   = kind_of(func);
        end else if (opcode == OP_POST) begin
            amode = AM_POST;
            acc   = kind_of(func);
        end else if (opcode[OPC_W-1:3] == DISP_HI) begin
            amode = AM_DISP;
            acc   = kind_of(opcode[2:0]);
        end else if (opcode == OP_CACHE) begin
            amode = AM_CACHE;
        end
    end

endmodule

// File: rtl/lsu_align.sv
module lsu_align
    import lsu_pkg::*;
(
    input  logic              active,
    input  logic [1:0]        lo,
    input  size_e             size,
    output logic              misalign,
    output logic [NBYTES-1:0] be
);
    always_comb begin
        misalign = 1'b0;
        be       = '0;
        if (active) begin
            case (size)
                SZ_WORD: begin
                    misalign = |lo;
                    be       = '1;
                end
                SZ_HALF: begin
                    misalign = lo[0];
                    be       = lo[1] ? 4'b1100 : 4'b0011;
                end
                default: be = 4'b0001 << lo;
            endcase
            if (misalign) be = '0;
        end
    end

endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
    import lsu_pkg::*;
(
    input  logic            en,
    input  logic [XLEN-1:0] word,
    input  logic [1:0]      lo,
    input  size_e           size,
    input  logic            sext,
    output logic [XLEN-1:0] value
);
    logic [7:0] lane [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane[g] = word[8*g +: 8];
    end

    logic [7:0]  b_sel;
    logic [15:0] h_sel;

    always_comb begin
        b_sel = lane[lo];
        h_sel = {lane[{lo[1], 1'b1}], lane[{lo[1], 1'b0}]};
        case (size)
            SZ_WORD: value = word;
            SZ_HALF: value = {{(XLEN-16){sext & h_sel[15]}}, h_sel};
            default: value = {{(XLEN-8){sext & b_sel[7]}}, b_sel};
        endcase
        if (!en) value = '0;
    end

endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [OPC_W-1:0]      req_opcode,
    input  logic [2:0]            req_func,
    input  logic [XLEN-1:0]       req_base,
    input  logic [IMM_W-1:0]      req_imm,
    input  logic [XLEN-1:0]       rd_word,
    output logic [XLEN-1:0]       mem_addr,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [1:0]            mem_size,
    output logic                  mem_sext,
    output logic [NBYTES-1:0]     mem_be,
    output logic                  misalign,
    output logic [XLEN-1:0]       base_next,
    output logic                  base_we,
    output logic [XLEN-1:0]       load_value
);
    typedef struct packed {
        logic [XLEN-1:0]   addr;
        logic              rd;
        logic              wr;
        size_e             size;
        logic              sext;
        logic [NBYTES-1:0] be;
        logic              mis;
        logic [XLEN-1:0]   bnext;
        logic              we;
    } state_t;

    state_t state_d, state_q;

    amode_e            amode_d;
    access_t           acc_d;
    logic [XLEN-1:0]   off_d, sum_d, eff_d;
    logic              active_d, mis_d, upd_d;
    logic [NBYTES-1:0] be_d;

    lsu_decode u_decode (
        .opcode (req_opcode),
        .func   (req_func),
        .amode  (amode_d),
        .acc    (acc_d)
    );

    always_comb begin
        upd_d    = (amode_d == AM_PRE) || (amode_d == AM_POST);
        off_d    = upd_d ? {{(XLEN-UPD_OFF_W){req_imm[UPD_OFF_W-1]}}, req_imm[UPD_OFF_W-1:0]}
                         : {{(XLEN-DISP_OFF_W){req_imm[DISP_OFF_W-1]}}, req_imm[DISP_OFF_W-1:0]};
        sum_d    = req_base + off_d;
        eff_d    = (amode_d == AM_POST) ? req_base : sum_d;
        active_d = req_valid && (acc_d.ld || acc_d.st);
    end

    lsu_align u_align (
        .active   (active_d),
        .lo       (eff_d[1:0]),
        .size     (acc_d.size),
        .misalign (mis_d),
        .be       (be_d)
    );

    always_comb begin
        state_d = '0;
        if (req_valid && amode_d != AM_NONE) state_d.addr = eff_d;
        if (active_d) begin
            state_d.size = acc_d.size;
            state_d.mis  = mis_d;
            if (!mis_d) begin
                state_d.rd   = acc_d.ld;
                state_d.wr   = acc_d.st;
                state_d.sext = acc_d.sext;
                state_d.be   = be_d;
                state_d.we   = upd_d;
                if (upd_d) state_d.bnext = sum_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign mem_addr  = state_q.addr;
    assign mem_rd    = state_q.rd;
    assign mem_wr    = state_q.wr;
    assign mem_size  = state_q.size;
    assign mem_sext  = state_q.sext;
    assign mem_be    = state_q.be;
    assign misalign  = state_q.mis;
    assign base_next = state_q.bnext;
    assign base_we   = state_q.we;

    lsu_load_ext u_ext (
        .en    (state_q.rd),
        .word  (rd_word),
        .lo    (state_q.addr[1:0]),
        .size  (state_q.size),
        .sext  (state_q.sext),
        .value (load_value)
    );

    p_rdwr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_sext_only_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sext |-> (mem_rd && mem_size != SZ_WORD));

    p_pre_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_opcode == OP_PRE) |=> (!base_we || base_next == mem_addr));

    p_post_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_opcode == OP_POST) |=>
        (!base_we || base_next == mem_addr +
            {{(XLEN-UPD_OFF_W){$past(req_imm[UPD_OFF_W-1])}}, $past(req_imm[UPD_OFF_W-1:0])}));

    p_disp_nowb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_opcode[OPC_W-1:3] == OP_DISP[OPC_W-1:3]) |=> !base_we);

    p_cache_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_opcode == OP_CACHE) |=> (!mem_rd && !mem_wr && !base_we && !misalign));

    p_be_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> ($countones(mem_be) ==
            ((mem_size == SZ_WORD) ? 4 : (mem_size == SZ_HALF) ? 2 : 1)));

    p_misalign_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_rd && !mem_wr && !base_we && mem_be == '0));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!mem_rd && !mem_wr && !base_we && !misalign));

endmodule

// File: tb/lsu_addr_gen_tb.sv
`timescale 1ns/1ps
module lsu_addr_gen_tb;

    localparam real CLK_NS = 4.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_opcode = '0;
    logic [2:0]  req_func = '0;
    logic [31:0] req_base = '0;
    logic [14:0] req_imm = '0;
    logic [31:0] rd_word = '0;
    logic [31:0] mem_addr, base_next, load_value;
    logic        mem_rd, mem_wr, mem_sext, misalign, base_we;
    logic [1:0]  mem_size;
    logic [3:0]  mem_be;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    lsu_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_func(req_func), .req_base(req_base), .req_imm(req_imm), .rd_word(rd_word),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_size(mem_size),
        .mem_sext(mem_sext), .mem_be(mem_be), .misalign(misalign),
        .base_next(base_next), .base_we(base_we), .load_value(load_value)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic quiet(input string tag);
        chk(tag, "mem_rd", {31'd0, mem_rd}, 32'd0);
        chk(tag, "mem_wr", {31'd0, mem_wr}, 32'd0);
        chk(tag, "base_we", {31'd0, base_we}, 32'd0);
        chk(tag, "misalign", {31'd0, misalign}, 32'd0);
        chk(tag, "mem_addr", mem_addr, 32'd0);
    endtask

    // Drive one request at a falling edge, sample its result at the next falling edge.
    task automatic run(input logic [4:0] opc, input logic [2:0] fn, input logic [31:0] base,
                       input logic [14:0] imm, input logic [31:0] word);
        bit pre, post, disp, cache, acc, is_ld, sg, mis, go;
        logic [2:0]  code;
        logic [1:0]  sz;
        logic [31:0] off, sum, a, sh, lv;
        logic [3:0]  be;
        string atag;
        req_valid = 1'b1; req_opcode = opc; req_func = fn;
        req_base = base; req_imm = imm; rd_word = word;
        @(negedge clk);
        pre = (opc == 5'h03); post = (opc == 5'h07);
        disp = (opc >= 5'h10 && opc <= 5'h17); cache = (opc == 5'h18);
        acc = pre || post || disp;
        code = disp ? opc[2:0] : fn;
        is_ld = !(code == 3'd4 || code == 3'd5 || code == 3'd7);
        sz = (code == 3'd0 || code == 3'd4) ? 2'd2 :
             (code == 3'd1 || code == 3'd2 || code == 3'd5) ? 2'd1 : 2'd0;
        sg = (code == 3'd1 || code == 3'd3);
        off = (pre || post) ? 32'($signed(imm[11:0])) : 32'($signed(imm));
        sum = base + off;
        a = post ? base : sum;
        mis = acc && ((sz == 2'd2 && a[1:0] != 2'd0) || (sz == 2'd1 && a[0]));
        go = acc && !mis;
        atag = pre ? "R3" : post ? "R4" : disp ? "R5" : cache ? "R6" : "R10";
        chk(atag, "mem_addr", mem_addr, (acc || cache) ? a : 32'd0);
        chk(atag, "base_we", {31'd0, base_we}, {31'd0, go && (pre || post)});
        chk(atag, "base_next", base_next, (go && (pre || post)) ? sum : 32'd0);
        chk("R2", "mem_rd", {31'd0, mem_rd}, {31'd0, go && is_ld});
        chk("R2", "mem_wr", {31'd0, mem_wr}, {31'd0, go && !is_ld});
        chk("R2", "mem_sext", {31'd0, mem_sext}, {31'd0, go && is_ld && sg});
        if (go) chk("R2", "mem_size", {30'd0, mem_size}, {30'd0, sz});
        chk("R8", "misalign", {31'd0, misalign}, {31'd0, mis});
        be = !go ? 4'd0 : (sz == 2'd2) ? 4'hF : (sz == 2'd1) ? (4'h3 << a[1:0]) : (4'h1 << a[1:0]);
        chk("R7", "mem_be", {28'd0, mem_be}, {28'd0, be});
        sh = word >> (8 * a[1:0]);
        if (!(go && is_ld))   lv = 32'd0;
        else if (sz == 2'd2)  lv = word;
        else if (sz == 2'd1)  lv = {{16{sg & sh[15]}}, sh[15:0]};
        else                  lv = {{24{sg & sh[7]}}, sh[7:0]};
        chk("R9", "load_value", load_value, lv);
    endtask

    initial begin
        logic [14:0] imms [4];
        logic [31:0] words [3];
        imms[0] = 15'h0004; imms[1] = 15'h7FFD; imms[2] = 15'h4802; imms[3] = 15'h2FFF;
        words[0] = 32'h80F1_7E92; words[1] = 32'h7F6E_8D0C; words[2] = 32'hFFFF_8001;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "mem_be", {28'd0, mem_be}, 32'd0);
        chk("R1", "mem_sext", {31'd0, mem_sext}, 32'd0);
        chk("R1", "load_value", load_value, 32'd0);
        quiet("R1");
        rst_n = 1'b1;
        @(negedge clk);
        quiet("R1");

        // R3 R4: update forms, every code, every remainder, offsets of both signs
        for (int op = 0; op < 2; op++)
            for (int f = 0; f < 8; f++)
                for (int lo = 0; lo < 4; lo++)
                    for (int k = 0; k < 4; k++)
                        run(op == 0 ? 5'h03 : 5'h07, 3'(f), 32'h1000_0100 + 32'(lo),
                            imms[k], words[(f + k) % 3]);

        // R5: displacement family, func input deliberately noisy
        for (int op = 16; op < 24; op++)
            for (int lo = 0; lo < 4; lo++)
                for (int k = 0; k < 4; k++)
                    run(5'(op), 3'(7 - (op % 8)), 32'h2000_0000 + 32'(lo * 5),
                        imms[k], words[(op + lo) % 3]);

        // R6: cache op
        for (int k = 0; k < 4; k++) run(5'h18, 3'd0, 32'h3000_0003, imms[k], words[0]);

        // R10: unknown opcodes and idle cycles
        run(5'h05, 3'd0, 32'h1234_5678, 15'h0010, words[1]);
        run(5'h1F, 3'd4, 32'h1234_5678, 15'h0010, words[1]);
        run(5'h03, 3'd0, 32'h0000_0040, 15'h0004, words[2]);
        req_valid = 1'b0;
        @(negedge clk);
        quiet("R10");

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule